// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a conditional branch in one clock cycle. It takes the fetched instruction word, the four arithmetic flags (carry, overflow, negative, zero) and the address of the instruction. From these it decides whether the branch is taken and which address is fetched next. A 4-bit condition field selects the test. Its low three bits pick one of eight base tests. Its top bit inverts the result, which gives both polarities of every test, and both signed and unsigned comparisons, from one small decoder.

The sequential address is the instruction address plus one instruction step of four bytes. A taken branch adds the sign-extended 23-bit offset to that sequential address. Only the branch opcode can report a taken branch. Every other opcode gets "not taken" and the sequential address, so a fetch stage can use the output as its next address without decoding anything else. Both outputs are registered: the result for the inputs present at a rising clock edge appears after that edge.

Top module: `brc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after the first rising edge with `rst_n` low, `taken_o` is 0 and `next_pc_o` is 0, whatever the inputs are.
- R2: Outputs are registered. After a rising edge, they show the result for the inputs sampled at that edge, and they do not follow input changes between edges.
- R3: The opcode is instruction bits 31..27. `taken_o` can be 1 only when that field equals 5'h08. Any other opcode gives `taken_o` = 0.
- R4: The condition field is instruction bits 26..23, and the flags input is {C,V,N,Z} with C in bit 3 and Z in bit 0. Code 4'b0000 is always taken. Code 4'b1000 is never taken.
- R5: Code 4'b0001 is taken when C is 0. Code 4'b1001 is taken when C is 1.
- R6: Code 4'b0010 is taken when V is 0. Code 4'b1010 is taken when V is 1.
- R7: Code 4'b0011 is taken when Z is 1. Code 4'b1011 is taken when Z is 0.
- R8: Code 4'b0100 (signed greater or equal) is taken when N equals V. Code 4'b1100 (signed less) is taken when N differs from V.
- R9: Code 4'b0101 (signed greater) is taken when Z is 0 and N equals V. Code 4'b1101 (signed less or equal) is taken when Z is 1 or N differs from V.
- R10: Code 4'b0110 is taken when N is 0. Code 4'b1110 is taken when N is 1.
- R11: Codes 4'b0111 and 4'b1111 are never taken, for all flag values.
- R12: For base codes 0 to 6, setting bit 3 of the condition field gives the opposite decision for the same flags.
- R13: The offset is instruction bits 22..0, read as two's complement. When the branch is taken, `next_pc_o` is PC + 4 + the sign-extended offset. When it is not taken, `next_pc_o` is PC + 4. Both sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word: opcode, condition field and offset |
| flags_i | input | 4 | Flags {C,V,N,Z} |
| pc_i | input | 32 | Address of the instruction |
| taken_o | output | 1 | Branch taken, registered |
| next_pc_o | output | 32 | Next fetch address, registered |

## Verification
The bench builds the block with its default parameters: a 32-bit instruction, a 5-bit opcode and a 32-bit address. With these values the offset is the full 23 bits below the condition field. This brings the largest positive and negative offsets within reach, as well as address wraparound at both ends of the 4 GiB space. Every condition code is driven against all sixteen flag patterns. The inversion pairs are then compared against each other, and random instruction words that mix branch and non-branch opcodes finish the run.

// File: rtl/brc_pkg.sv
// Package: shared types for the branch resolver.
// Assumes a 4-bit condition field: a 3-bit base test plus an invert bit on top.
package brc_pkg;

    localparam int BRC_COND_W = 4;

    typedef enum logic [2:0] {
        BASE_TRUE = 3'd0,
        BASE_NC   = 3'd1,
        BASE_NV   = 3'd2,
        BASE_Z    = 3'd3,
        BASE_GE   = 3'd4,
        BASE_GT   = 3'd5,
        BASE_NN   = 3'd6,
        BASE_NONE = 3'd7
    } brc_base_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } brc_flags_t;

endpackage

// File: rtl/brc_cond_eval.sv
// Condition evaluator: decodes the base test from the low three bits and
// inverts it with the top bit. Base 7 is never true in either polarity.
// Purely combinational.
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [BRC_COND_W-1:0] cond_i,
    input  brc_flags_t            flags_i,
    output logic                  hit_o
);

    brc_base_e base;
    logic      base_hit;
    logic      sgn_ge;
    logic      invert;

    assign base = brc_base_e'(cond_i[BRC_COND_W-2:0]);

    // Evaluate the selected base test on the flags.
    always_comb begin
        sgn_ge = ~(flags_i.n ^ flags_i.v);
        unique case (base)
            BASE_TRUE: base_hit = 1'b1;
            BASE_NC:   base_hit = ~flags_i.c;
            BASE_NV:   base_hit = ~flags_i.v;
            BASE_Z:    base_hit = flags_i.z;
            BASE_GE:   base_hit = sgn_ge;
            BASE_GT:   base_hit = sgn_ge & ~flags_i.z;
            BASE_NN:   base_hit = ~flags_i.n;
            default:   base_hit = 1'b0;
        endcase
    end

    // Apply the invert bit, except for base 7, which never fires.
    always_comb begin
        invert = cond_i[BRC_COND_W-1] && (base != BASE_NONE);
        hit_o  = base_hit ^ invert;
    end

endmodule

// File: rtl/brc_target_calc.sv
// Target calculator: forms the sequential address and the taken target.
// Assumes the offset is two's complement and added unscaled to the sequential address.
module brc_target_calc #(
    parameter int PC_W    = 32,
    parameter int OFFS_W  = 23,
    parameter int PC_STEP = 4
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic [PC_W-1:0]   seq_pc_o,
    output logic [PC_W-1:0]   tgt_pc_o
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    logic [PC_W-1:0] offs_ext;

    // Sign-extend or truncate the offset to the address width.
    generate
        if (PC_W > OFFS_W) begin : g_ext
            assign offs_ext = {{(PC_W-OFFS_W){offs_i[OFFS_W-1]}}, offs_i};
        end else begin : g_trunc
            assign offs_ext = offs_i[PC_W-1:0];
        end
    endgenerate

    // Sequential and branch target sums, both wrap at the address width.
    always_comb begin
        seq_pc_o = pc_i + STEP_V;
        tgt_pc_o = seq_pc_o + offs_ext;
    end

endmodule

// File: rtl/brc_branch_unit.sv
// Branch resolver top: splits the instruction into its fields, gates the
// condition by the branch opcode and registers the decision and the next address.
// Assumes the opcode sits in the top bits, the condition field directly below
// it, and the offset fills the remaining low bits.
module brc_branch_unit
    import brc_pkg::*;
#(
    parameter int               INSTR_W = 32,
    parameter int               OPC_W   = 5,
    parameter int               PC_W    = 32,
    parameter int               PC_STEP = 4,
    parameter logic [OPC_W-1:0] BR_OPC  = OPC_W'(8)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INSTR_W-1:0]    instr_i,
    input  logic [BRC_COND_W-1:0] flags_i,
    input  logic [PC_W-1:0]       pc_i,
    output logic                  taken_o,
    output logic [PC_W-1:0]       next_pc_o
);

    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int COND_LSB = OPC_LSB - BRC_COND_W;
    localparam int OFFS_W   = COND_LSB;

    logic [OPC_W-1:0]      opc;
    logic [BRC_COND_W-1:0] cond;
    logic [OFFS_W-1:0]     offs;
    logic                  cond_hit;
    logic                  take_d;
    logic [PC_W-1:0]       seq_pc;
    logic [PC_W-1:0]       tgt_pc;

    assign opc  = instr_i[INSTR_W-1:OPC_LSB];
    assign cond = instr_i[OPC_LSB-1:COND_LSB];
    assign offs = instr_i[OFFS_W-1:0];

    brc_cond_eval u_cond (
        .cond_i  (cond),
        .flags_i (brc_flags_t'(flags_i)),
        .hit_o   (cond_hit)
    );

    brc_target_calc #(
        .PC_W    (PC_W),
        .OFFS_W  (OFFS_W),
        .PC_STEP (PC_STEP)
    ) u_tgt (
        .pc_i     (pc_i),
        .offs_i   (offs),
        .seq_pc_o (seq_pc),
        .tgt_pc_o (tgt_pc)
    );

    // Only the branch opcode may take the condition result.
    assign take_d = (opc == BR_OPC) && cond_hit;

    // Register the decision and the selected next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else begin
            taken_o   <= take_d;
            next_pc_o <= take_d ? tgt_pc : seq_pc;
        end
    end

endmodule

// File: rtl/brc_branch_checker.sv
// Checker for the branch resolver: relates registered outputs to the inputs
// of the previous cycle. Attached to the top by the bind below.
module brc_branch_checker #(
    parameter int               INSTR_W = 32,
    parameter int               OPC_W   = 5,
    parameter int               PC_W    = 32,
    parameter int               PC_STEP = 4,
    parameter logic [OPC_W-1:0] BR_OPC  = OPC_W'(8)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [INSTR_W-1:0]   instr_i,
    input logic [3:0]           flags_i,
    input logic [PC_W-1:0]      pc_i,
    input logic                 taken_o,
    input logic [PC_W-1:0]      next_pc_o
);

    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int COND_LSB = OPC_LSB - 4;
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    logic [OPC_W-1:0] opc;
    logic [3:0]       cond;
    logic             is_br;

    assign opc   = instr_i[INSTR_W-1:OPC_LSB];
    assign cond  = instr_i[OPC_LSB-1:COND_LSB];
    assign is_br = (opc == BR_OPC);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!taken_o && next_pc_o == '0)); // R1
    AST_OPC_GATE: assert property (@(posedge clk) disable iff (!rst_n) !is_br |=> !taken_o); // R3
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (is_br && cond == 4'b0000) |=> taken_o); // R4
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (is_br && cond == 4'b1000) |=> !taken_o); // R4
    AST_EQUAL_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n) (is_br && cond == 4'b0011) |=> (taken_o == $past(flags_i[0]))); // R7
    AST_BASE7_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (cond[2:0] == 3'b111) |=> !taken_o); // R11
    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !is_br |=> (next_pc_o == $past(pc_i) + STEP_V)); // R13

endmodule

bind brc_branch_unit brc_branch_checker #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP),
    .BR_OPC  (BR_OPC)
) u_chk (.*);

// File: tb/brc_branch_unit_bench.sv
// Bench for the branch resolver: directed corner cases plus seeded random words.
module brc_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [3:0]  flags_i = '0;
    logic [31:0] pc_i = '0;
    logic        taken_o;
    logic [31:0] next_pc_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brc_branch_unit u_brc_branch_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr_i),
        .flags_i   (flags_i),
        .pc_i      (pc_i),
        .taken_o   (taken_o),
        .next_pc_o (next_pc_o)
    );

    function automatic logic [31:0] mk(input logic [4:0] opc, input logic [3:0] cd, input logic [22:0] imm);
        return {opc, cd, imm};
    endfunction

    // Expected decision, written straight from the code table.
    function automatic bit exp_taken(input logic [31:0] ins, input logic [3:0] f);
        bit c = f[3], v = f[2], n = f[1], z = f[0];
        if (ins[31:27] != 5'h08) return 1'b0;
        case (ins[26:23])
            4'b0000: return 1'b1;
            4'b1000: return 1'b0;
            4'b0001: return !c;
            4'b1001: return c;
            4'b0010: return !v;
            4'b1010: return v;
            4'b0011: return z;
            4'b1011: return !z;
            4'b0100: return n == v;
            4'b1100: return n != v;
            4'b0101: return !z && (n == v);
            4'b1101: return z || (n != v);
            4'b0110: return !n;
            4'b1110: return n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_pc(input logic [31:0] ins, input logic [3:0] f, input logic [31:0] pc);
        logic [31:0] seq = pc + 32'd4;
        if (exp_taken(ins, f)) return seq + {{9{ins[22]}}, ins[22:0]};
        return seq;
    endfunction

    function automatic string req_of(input logic [31:0] ins);
        if (ins[31:27] != 5'h08) return "R3";
        case (ins[25:23])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(input logic [31:0] ins, input logic [3:0] f, input logic [31:0] pc, input string preq);
        bit          et;
        logic [31:0] ep;
        @(negedge clk);
        instr_i = ins; flags_i = f; pc_i = pc;
        et = exp_taken(ins, f);
        ep = exp_pc(ins, f, pc);
        @(negedge clk);
        chk(taken_o == et, req_of(ins), {31'd0, taken_o}, {31'd0, et});
        chk(next_pc_o == ep, preq, next_pc_o, ep);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        bit t0;
        bit t1;
        void'($urandom(32'h5EED_1234));
        // R1: reset holds outputs at zero even with an always-branch applied.
        instr_i = mk(5'h08, 4'b0000, 23'h10); pc_i = 32'h100;
        repeat (3) @(negedge clk);
        chk(taken_o == 1'b0, "R1", {31'd0, taken_o}, 32'd0);
        chk(next_pc_o == 32'd0, "R1", next_pc_o, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: output holds between edges, then updates.
        apply(mk(5'h08, 4'b0000, 23'h10), 4'h0, 32'h100, "R13");
        @(negedge clk);
        instr_i = mk(5'h00, 4'b0000, 23'h10); pc_i = 32'h200;
        #1;
        chk(taken_o == 1'b1, "R2", {31'd0, taken_o}, 32'd1);
        chk(next_pc_o == 32'h114, "R2", next_pc_o, 32'h114);
        @(negedge clk);
        chk(taken_o == 1'b0, "R2", {31'd0, taken_o}, 32'd0);
        chk(next_pc_o == 32'h204, "R2", next_pc_o, 32'h204);

        // R4..R11: every code against every flag pattern.
        for (int cd = 0; cd < 16; cd++)
            for (int f = 0; f < 16; f++)
                apply(mk(5'h08, 4'(cd), 23'h40), 4'(f), 32'h1000 + 32'(cd * 64), "R13");

        // R3: near-miss opcodes with an always code never take.
        apply(mk(5'h18, 4'b0000, 23'h40), 4'h0, 32'h300, "R3");
        apply(mk(5'h09, 4'b0000, 23'h40), 4'hF, 32'h300, "R3");
        apply(mk(5'h00, 4'b0011, 23'h40), 4'h1, 32'h300, "R3");

        // R12: the invert bit flips every base 0..6 decision.
        for (int b = 0; b < 7; b++)
            for (int f = 0; f < 16; f++) begin
                apply(mk(5'h08, 4'(b), 23'h0), 4'(f), 32'h0, "R13");
                t0 = taken_o;
                apply(mk(5'h08, 4'(b) | 4'b1000, 23'h0), 4'(f), 32'h0, "R13");
                t1 = taken_o;
                chk(t0 != t1, "R12", {31'd0, t1}, {31'd0, !t0});
            end

        // R13: offset extremes and wraparound.
        apply(mk(5'h08, 4'b0000, 23'h3FFFFF), 4'h0, 32'h0, "R13");
        apply(mk(5'h08, 4'b0000, 23'h400000), 4'h0, 32'h0, "R13");
        apply(mk(5'h08, 4'b0000, 23'h7FFFF8), 4'h0, 32'h4, "R13");
        apply(mk(5'h00, 4'b0000, 23'h0), 4'h0, 32'hFFFF_FFFC, "R13");
        apply(mk(5'h08, 4'b0000, 23'h8), 4'h0, 32'hFFFF_FFF8, "R13");

        // Random mix, half on the branch opcode.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins = $urandom;
            if ($urandom_range(1, 0) == 1) ins[31:27] = 5'h08;
            apply(ins, 4'($urandom), $urandom, "R13");
        end

        // R1: reset in mid-run clears the outputs again.
        @(negedge clk);
        rst_n = 1'b0; instr_i = mk(5'h08, 4'b0000, 23'h1); pc_i = 32'h50;
        @(negedge clk);
        chk(taken_o == 1'b0, "R1", {31'd0, taken_o}, 32'd0);
        chk(next_pc_o == 32'd0, "R1", next_pc_o, 32'd0);
        rst_n = 1'b1;
        finish_run();
    end

endmodule